// File: doc/BRIEF.md
# Sideband-Matched Variable-Latency Unit Wrapper

This block sits in front of an external processing unit whose latency can change from one item to the next. Each input item carries a data word, which is sent to the unit, and a sideband tag (sync flags, frame markers, sequence numbers) that does not pass through the unit. The tag waits in a small FIFO inside the wrapper. When the unit hands back a result, the oldest waiting tag is taken from the FIFO and sent out with it. Because the unit keeps issue order, each tag leaves next to the result of its own item, whatever the latency.

Work is admitted only while the unit is ready and the tag FIFO has a free slot. The FIFO depth is the largest number of items that may be in flight, so a FIFO that never overflows also bounds the unit's occupancy. The output side is a valid/ready port with backpressure. While the consumer stalls, both the unit's result and the head tag are held in place.

Top module: `sideband_match`

## Requirements
- R1: `in_ready` equals `unit_ready` AND (occupancy < DEPTH). `unit_req_valid` equals `in_valid` AND (occupancy < DEPTH). Occupancy is the number of accepted items whose result has not yet left on the output port.
- R2: `unit_req_data` carries `in_data` unchanged in the same cycle.
- R3: Occupancy never exceeds DEPTH (default 8). With a unit that can hold more than DEPTH items, the occupancy still reaches exactly DEPTH, and no further item is accepted until one leaves.
- R4: `out_valid` equals `unit_res_valid` AND (occupancy > 0). `out_data` equals `unit_res_data`.
- R5: Outputs leave in acceptance order. Each `out_tag` is the `in_tag` of the item whose result is on `out_data`.
- R6: While `out_valid` is high and `out_ready` is low, nothing is consumed. In the next cycle `out_valid` stays high and `out_tag` and `out_data` are unchanged.
- R7: `unit_res_ready` equals `out_ready` AND (occupancy > 0). A unit result that is presented while the FIFO is empty is a protocol violation, and an assertion flags it.
- R8: While `rst_n` is low, and directly after reset, the FIFO is empty. `out_valid` is low and `in_ready` follows `unit_ready`.
- R9: An accept and an output in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted when high with in_valid |
| in_data | input | DW | Data word for the unit |
| in_tag | input | TW | Sideband tag for the item |
| unit_req_valid | output | 1 | Issue request to the unit |
| unit_ready | input | 1 | Unit can take a new item |
| unit_req_data | output | DW | Data issued to the unit |
| unit_res_valid | input | 1 | Unit result valid |
| unit_res_ready | output | 1 | Unit result consumed |
| unit_res_data | input | DW | Unit result data |
| out_valid | output | 1 | Output valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | DW | Result data |
| out_tag | output | TW | Tag matched to the result |

## Verification
The unit stub runs in four phases:
- Short latency with a free consumer checks basic pairing and same-cycle push and pop.
- Long latency with heavy backpressure fills the FIFO to DEPTH, which tells correct admission gating apart from overflow.
- A toggling `unit_ready` separates the unit-side gate from the FIFO-side gate.
- Latency-one streaming with random stalls shows whether held results keep their tag.

In every phase the tag sequence is compared against a queue model that is updated on each handshake.

// File: rtl/sideband_match.sv
module sideband_match #(
  parameter int DW    = 8,
  parameter int TW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [TW-1:0] in_tag,
  output logic          unit_req_valid,
  input  logic          unit_ready,
  output logic [DW-1:0] unit_req_data,
  input  logic          unit_res_valid,
  output logic          unit_res_ready,
  input  logic [DW-1:0] unit_res_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [TW-1:0] out_tag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [TW-1:0] tags [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] occ;
  logic          room, any, push, pop;

  assign room = occ < FULL;
  assign any  = occ != '0;

  assign in_ready       = unit_ready & room;
  assign unit_req_valid = in_valid & room;
  assign unit_req_data  = in_data;
  assign push           = in_valid & in_ready;

  assign out_valid      = unit_res_valid & any;
  assign unit_res_ready = out_ready & any;
  assign out_data       = unit_res_data;
  assign out_tag        = tags[rp];
  assign pop            = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) begin
        tags[wp] <= in_tag;
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  a_r3_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);
  a_r1_no_admit_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL) |-> !in_ready);
  a_r7_result_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    unit_res_valid |-> any);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)));
  a_r9_balanced_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(occ));
endmodule

// File: tb/sim_sideband_match.sv
`timescale 1ns/1ps
module sim_sideband_match;
  localparam int DW = 8, TW = 8, DEPTH = 8, UCAP = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, unit_ready = 0, unit_res_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0, unit_res_data = '0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, unit_req_valid, unit_res_ready, out_valid;
  logic [DW-1:0] unit_req_data, out_data;
  logic [TW-1:0] out_tag;

  always #2.5 clk = ~clk;

  sideband_match #(.DW(DW), .TW(TW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_tag(in_tag), .unit_req_valid(unit_req_valid),
    .unit_ready(unit_ready), .unit_req_data(unit_req_data),
    .unit_res_valid(unit_res_valid), .unit_res_ready(unit_res_ready),
    .unit_res_data(unit_res_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  logic [DW-1:0] sq_data[$];
  int            sq_due[$];
  logic [DW-1:0] ex_data[$];
  logic [TW-1:0] ex_tag[$];

  initial begin
    int cyc = 0, last_due = 0, max_occ = 0, occ_before;
    logic [TW-1:0] seq = '0;
    bit held = 0;
    logic [TW-1:0] held_tag;
    logic [DW-1:0] held_data;

    // R8: reset state, with a stray result and backpressure that must be ignored
    unit_res_valid = 1; unit_ready = 1; out_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 0, "R8 out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R8 in_ready follows unit_ready", in_ready, 1);
    unit_ready = 0; #0.5;
    check(in_ready == 0, "R8 in_ready follows unit_ready low", in_ready, 0);
    @(negedge clk);
    unit_res_valid = 0; rst_n = 1;

    for (int phase = 0; phase < 4; phase++) begin
      for (int n = 0; n < 1500; n++) begin
        bit acc, op, up;
        int occ;
        @(negedge clk);
        cyc++;
        occ = ex_data.size();
        // phase 0: short latency, free output; 1: long latency, heavy stall;
        // 2: toggling unit_ready; 3: latency one, random stalls
        in_valid = ($urandom_range(0, 3) != 0);
        in_data  = DW'($urandom);
        in_tag   = seq;
        unit_ready = (sq_data.size() < UCAP) &&
                     ((phase == 2) ? ($urandom_range(0, 1) == 1) : 1'b1);
        case (phase)
          0: out_ready = 1;
          1: out_ready = ($urandom_range(0, 4) == 0);
          2: out_ready = ($urandom_range(0, 1) == 1);
          default: out_ready = ($urandom_range(0, 2) != 0);
        endcase
        unit_res_valid = (sq_data.size() > 0) && (sq_due[0] <= cyc);
        unit_res_data  = unit_res_valid ? sq_data[0] : '0;
        #1;
        check(in_ready == (unit_ready && occ < DEPTH), "R1 in_ready", in_ready, unit_ready && occ < DEPTH);
        check(unit_req_valid == (in_valid && occ < DEPTH), "R1 unit_req_valid", unit_req_valid, in_valid && occ < DEPTH);
        check(unit_req_data == in_data, "R2 unit_req_data", unit_req_data, in_data);
        check(out_valid == (unit_res_valid && occ > 0), "R4 out_valid", out_valid, unit_res_valid && occ > 0);
        check(unit_res_ready == (out_ready && occ > 0), "R7 unit_res_ready", unit_res_ready, out_ready && occ > 0);
        if (out_valid) begin
          check(out_data == unit_res_data, "R4 out_data", out_data, unit_res_data);
          if (occ > 0) begin
            check(out_tag == ex_tag[0], "R5 out_tag", out_tag, ex_tag[0]);
            check(out_data == ex_data[0], "R5 out_data order", out_data, ex_data[0]);
          end
        end
        if (held) begin
          check(out_valid == 1, "R6 held valid", out_valid, 1);
          check(out_tag == held_tag, "R6 held tag", out_tag, held_tag);
          check(out_data == held_data, "R6 held data", out_data, held_data);
        end
        acc = in_valid && in_ready;
        op  = out_valid && out_ready;
        up  = unit_res_valid && unit_res_ready;
        held = out_valid && !out_ready;
        held_tag = out_tag; held_data = out_data;
        occ_before = occ;
        @(posedge clk);
        if (acc) begin
          int due = cyc + ((phase == 1) ? $urandom_range(4, 20) :
                           (phase == 3) ? 1 : $urandom_range(1, 6));
          if (due < last_due) due = last_due;
          last_due = due;
          sq_data.push_back(~in_data); sq_due.push_back(due);
          ex_data.push_back(~in_data); ex_tag.push_back(in_tag);
          seq++;
        end
        if (up) begin void'(sq_data.pop_front()); void'(sq_due.pop_front()); end
        if (op) begin void'(ex_data.pop_front()); void'(ex_tag.pop_front()); end
        if (ex_data.size() > max_occ) max_occ = ex_data.size();
        if (acc && op) check(ex_data.size() == occ_before, "R9 push+pop occupancy", ex_data.size(), occ_before);
      end
    end
    check(max_occ == DEPTH, "R3 occupancy reaches DEPTH", max_occ, DEPTH);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule